// File: doc/BRIEF.md
# Branch-and-Link / Decrement-and-Branch Execute Unit

This unit finishes two branch instructions for a 32-bit processor whose bit 0 is the most significant bit. For a branch that stores a link, it forms the link value from the address of the next sequential instruction. It writes that value to general register R and then moves the instruction address to the effective virtual address. For a branch that decrements a counter, it writes R minus one back to R. It branches only when the decremented count is not zero.

The fetch of the branch target can report three faults: the target is protected against instruction access in the current mode, the target address does not exist, or the target word has a parity error. A fault on a taken branch aborts the instruction and raises a trap. What R holds after the abort depends on the instruction. A link branch has always written its link value, whatever the fault. A decrement branch leaves R at its old value. The trap handler receives the address of the aborted instruction itself.

A one-cycle `start` strobe hands the unit its operands. Every result appears as a one-cycle pulse on the next clock edge.

Top module: `brlink_exec`

## Requirements
- R1: In normal addressing (`extMode`=0), a link branch with no fault drives, one cycle after `start`, `regWe`=1 and `iaWe`=1 in the same cycle. It also drives `regData` = (instAddr+1) with its 15 most significant bits cleared, keeping the 17 low bits, and `iaOut` = `effAddr`.
- R2: In extended addressing (`extMode`=1), the link value is (instAddr+1) with only its 10 most significant bits cleared, keeping the 22 low bits.
- R3: `op`=1 selects the decrement branch and `op`=0 the link branch. A decrement branch writes `regIn`−1 (modulo 2^32) to R. When that value is not zero, the branch is taken and `iaOut` = `effAddr`.
- R4: When the decremented value is zero, the branch is not taken. R is written with 0, `iaOut` = instAddr+1, and every fault input is ignored, so no trap is raised.
- R5: A taken branch with `faultProt` or `faultNoMem` set aborts. The unit raises `trapReq` with `trapVec`=7'h40 and `trapSaveAddr`=`instAddr`, and `iaWe` stays 0.
- R6: On a 7'h40 abort, a link branch still writes its link value to R (`regWe`=1). A decrement branch does not write R (`regWe`=0).
- R7: A taken branch with only `faultParity` set aborts with `trapVec`=7'h4C, `trapSaveAddr`=`instAddr` and `iaWe`=0. A link branch writes its link value to R and a decrement branch does not.
- R8: When a protection or nonexistent-address fault is present together with a parity fault, the 7'h40 abort wins.
- R9: After reset, and in every cycle not directly after `start`, `regWe`, `iaWe` and `trapReq` are 0. Every result is a single-cycle pulse, and `trapReq` and `iaWe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe: operands valid, execute |
| op | input | 1 | 0 = branch and link, 1 = decrement and branch |
| extMode | input | 1 | 1 = extended real addressing (wider link field) |
| instAddr | input | 32 | Address of the instruction being executed |
| effAddr | input | 32 | Effective virtual address of the branch target |
| regIn | input | 32 | Current contents of register R |
| faultProt | input | 1 | Target protected against instruction access |
| faultNoMem | input | 1 | Target address does not exist |
| faultParity | input | 1 | Parity error fetching the target word |
| iaWe | output | 1 | Instruction-address update strobe |
| iaOut | output | 32 | New instruction address |
| regWe | output | 1 | Register R write strobe |
| regData | output | 32 | Data for register R |
| trapReq | output | 1 | Trap request pulse |
| trapVec | output | 7 | Trap vector address |
| trapSaveAddr | output | 32 | Address saved for the trap handler |

## Verification
The bench targets the places where the two instructions split on an abort. A design that mixed up the instructions would leave a link branch's R unwritten on a fault, or would let a decrement branch corrupt its counter. It also checks the link field width in each addressing mode with addresses that carry into the cleared high bits. A wrong mask there would leak high bits into R or truncate the extended link. It drives a counter that decrements to zero while faults are asserted, and a counter that wraps from zero; a design that checked faults on a branch not taken would raise a false trap. Two further cases are simultaneous faults, where the wrong priority gives vector 7'h4C, and the pulse width of every strobe.

// File: rtl/brlink_pkg.sv
package brlink_pkg;

  typedef enum logic {
    OP_LINK  = 1'b0,
    OP_DECBR = 1'b1
  } brOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic regWr;     // write register R this cycle
    logic iaWr;      // commit new instruction address
    logic trapFire;  // raise a trap
    logic vecParity; // 1: parity vector, 0: access vector
    logic seqNext;   // 1: next sequential address, 0: target
    logic selDec;    // 1: R data is decremented count, 0: link value
  } brStrobe_t;

endpackage

// File: rtl/brlink_ctrl.sv
module brlink_ctrl
  import brlink_pkg::*;
(
  input  logic      start,
  input  brOp_e     op,
  input  logic      accFault,
  input  logic      parFault,
  input  logic      decZero,
  output brStrobe_t strb
);

  logic isLink;
  logic taken;
  logic accAbort;
  logic parAbort;
  logic anyAbort;

  always_comb begin
    isLink   = (op == OP_LINK);
    // link always branches; decrement branches on nonzero result
    taken    = isLink || !decZero;
    // access-type faults outrank the parity fault
    accAbort = taken && accFault;
    parAbort = taken && !accFault && parFault;
    anyAbort = accAbort || parAbort;

    strb.trapFire  = start && anyAbort;
    strb.vecParity = parAbort;
    // link value is written even when aborted; counter kept on abort
    strb.regWr     = start && (isLink || !anyAbort);
    strb.iaWr      = start && !anyAbort;
    strb.seqNext   = !taken;
    strb.selDec    = !isLink;
  end

endmodule

// File: rtl/brlink_dpath.sv
module brlink_dpath
  import brlink_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NORM_CLR = 15,
  parameter int EXT_CLR  = 10,
  parameter int VEC_W    = 7,
  parameter logic [VEC_W-1:0] ACC_VEC = 7'h40,
  parameter logic [VEC_W-1:0] PAR_VEC = 7'h4C
) (
  input  logic              clk,
  input  logic              rstN,
  input  brStrobe_t         strb,
  input  logic              extMode,
  input  logic [DATA_W-1:0] instAddr,
  input  logic [DATA_W-1:0] effAddr,
  input  logic [DATA_W-1:0] regIn,
  output logic              decZero,
  output logic              iaWe,
  output logic [DATA_W-1:0] iaOut,
  output logic              regWe,
  output logic [DATA_W-1:0] regData,
  output logic              trapReq,
  output logic [VEC_W-1:0]  trapVec,
  output logic [DATA_W-1:0] trapSaveAddr
);

  localparam int NORM_KEEP = DATA_W - NORM_CLR;
  localparam int EXT_KEEP  = DATA_W - EXT_CLR;
  localparam logic [DATA_W-1:0] NORM_MASK = {{NORM_CLR{1'b0}}, {NORM_KEEP{1'b1}}};
  localparam logic [DATA_W-1:0] EXT_MASK  = {{EXT_CLR{1'b0}}, {EXT_KEEP{1'b1}}};
  localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] nextSeq;
  logic [DATA_W-1:0] linkVal;
  logic [DATA_W-1:0] decVal;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] newIa;

  always_comb begin
    nextSeq = instAddr + ONE;
    linkVal = nextSeq & (extMode ? EXT_MASK : NORM_MASK);
    decVal  = regIn - ONE;
    decZero = (decVal == '0);
    wrData  = strb.selDec ? decVal : linkVal;
    newIa   = strb.seqNext ? nextSeq : effAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iaWe         <= 1'b0;
      iaOut        <= '0;
      regWe        <= 1'b0;
      regData      <= '0;
      trapReq      <= 1'b0;
      trapVec      <= '0;
      trapSaveAddr <= '0;
    end else begin
      iaWe    <= strb.iaWr;
      regWe   <= strb.regWr;
      trapReq <= strb.trapFire;
      if (strb.iaWr) iaOut <= newIa;
      if (strb.regWr) regData <= wrData;
      if (strb.trapFire) begin
        trapVec      <= strb.vecParity ? PAR_VEC : ACC_VEC;
        trapSaveAddr <= instAddr;
      end
    end
  end

endmodule

// File: rtl/brlink_exec.sv
module brlink_exec
  import brlink_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NORM_CLR = 15,
  parameter int EXT_CLR  = 10,
  parameter int VEC_W    = 7,
  parameter logic [VEC_W-1:0] ACC_VEC = 7'h40,
  parameter logic [VEC_W-1:0] PAR_VEC = 7'h4C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              op,
  input  logic              extMode,
  input  logic [DATA_W-1:0] instAddr,
  input  logic [DATA_W-1:0] effAddr,
  input  logic [DATA_W-1:0] regIn,
  input  logic              faultProt,
  input  logic              faultNoMem,
  input  logic              faultParity,
  output logic              iaWe,
  output logic [DATA_W-1:0] iaOut,
  output logic              regWe,
  output logic [DATA_W-1:0] regData,
  output logic              trapReq,
  output logic [VEC_W-1:0]  trapVec,
  output logic [DATA_W-1:0] trapSaveAddr
);

  brStrobe_t strb;
  logic      decZero;
  brOp_e     opKind;

  assign opKind = brOp_e'(op);

  brlink_ctrl u_ctrl (
    .start    (start),
    .op       (opKind),
    .accFault (faultProt | faultNoMem),
    .parFault (faultParity),
    .decZero  (decZero),
    .strb     (strb)
  );

  brlink_dpath #(
    .DATA_W  (DATA_W),
    .NORM_CLR(NORM_CLR),
    .EXT_CLR (EXT_CLR),
    .VEC_W   (VEC_W),
    .ACC_VEC (ACC_VEC),
    .PAR_VEC (PAR_VEC)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .extMode     (extMode),
    .instAddr    (instAddr),
    .effAddr     (effAddr),
    .regIn       (regIn),
    .decZero     (decZero),
    .iaWe        (iaWe),
    .iaOut       (iaOut),
    .regWe       (regWe),
    .regData     (regData),
    .trapReq     (trapReq),
    .trapVec     (trapVec),
    .trapSaveAddr(trapSaveAddr)
  );

endmodule

// File: rtl/brlink_exec_chk.sv
module brlink_exec_chk #(
  parameter int DATA_W = 32,
  parameter int VEC_W  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              op,
  input logic [DATA_W-1:0] instAddr,
  input logic              faultProt,
  input logic              faultNoMem,
  input logic              faultParity,
  input logic              iaWe,
  input logic              regWe,
  input logic              trapReq,
  input logic [VEC_W-1:0]  trapVec,
  input logic [DATA_W-1:0] trapSaveAddr
);

  // R9
  trap_commit_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(trapReq && iaWe));

  // R9
  strobe_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe || iaWe || trapReq) |-> $past(start));

  // R1
  link_commit_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (iaWe && !$past(op)) |-> regWe);

  // R6
  decbr_abort_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && $past(op)) |-> !regWe);

  // R6
  link_abort_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !$past(op)) |-> regWe);

  // R5
  trap_save_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (trapSaveAddr == $past(instAddr)));

  // R8
  acc_over_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && $past(faultProt || faultNoMem)) |-> (trapVec == 7'h40));

  // R7
  parity_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && $past(!faultProt && !faultNoMem && faultParity)) |-> (trapVec == 7'h4C));

endmodule

bind brlink_exec brlink_exec_chk #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .op          (op),
  .instAddr    (instAddr),
  .faultProt   (faultProt),
  .faultNoMem  (faultNoMem),
  .faultParity (faultParity),
  .iaWe        (iaWe),
  .regWe       (regWe),
  .trapReq     (trapReq),
  .trapVec     (trapVec),
  .trapSaveAddr(trapSaveAddr)
);

// File: tb/brlink_exec_test.sv
module brlink_exec_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic        extMode = 1'b0;
  logic [31:0] instAddr = '0;
  logic [31:0] effAddr = '0;
  logic [31:0] regIn = '0;
  logic        faultProt = 1'b0;
  logic        faultNoMem = 1'b0;
  logic        faultParity = 1'b0;
  logic        iaWe;
  logic [31:0] iaOut;
  logic        regWe;
  logic [31:0] regData;
  logic        trapReq;
  logic [6:0]  trapVec;
  logic [31:0] trapSaveAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  brlink_exec uut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .extMode(extMode),
    .instAddr(instAddr), .effAddr(effAddr), .regIn(regIn),
    .faultProt(faultProt), .faultNoMem(faultNoMem), .faultParity(faultParity),
    .iaWe(iaWe), .iaOut(iaOut), .regWe(regWe), .regData(regData),
    .trapReq(trapReq), .trapVec(trapVec), .trapSaveAddr(trapSaveAddr)
  );

  typedef struct packed {
    logic        op;
    logic        ext;
    logic [31:0] ia;
    logic [31:0] eva;
    logic [31:0] rin;
    logic        prot;
    logic        nomem;
    logic        par;
    logic        eWe;
    logic [31:0] eData;
    logic        eIaWe;
    logic [31:0] eIa;
    logic        eTrap;
    logic [6:0]  eVec;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    // R1 plain link
    '{1'b0, 1'b0, 32'h0001_2345, 32'h0000_0800, 32'h0, 1'b0, 1'b0, 1'b0,
      1'b1, 32'h0001_2346, 1'b1, 32'h0000_0800, 1'b0, 7'h00, 4'd1},
    // R1 carry into cleared bits
    '{1'b0, 1'b0, 32'h0045_FFFF, 32'h0000_1234, 32'h0, 1'b0, 1'b0, 1'b0,
      1'b1, 32'h0000_0000, 1'b1, 32'h0000_1234, 1'b0, 7'h00, 4'd1},
    // R2 extended, same address
    '{1'b0, 1'b1, 32'h0045_FFFF, 32'h0000_0055, 32'h0, 1'b0, 1'b0, 1'b0,
      1'b1, 32'h0006_0000, 1'b1, 32'h0000_0055, 1'b0, 7'h00, 4'd2},
    // R2 extended, high bits masked
    '{1'b0, 1'b1, 32'h0ABC_DEF0, 32'h0000_0200, 32'h0, 1'b0, 1'b0, 1'b0,
      1'b1, 32'h003C_DEF1, 1'b1, 32'h0000_0200, 1'b0, 7'h00, 4'd2},
    // R3 decrement taken
    '{1'b1, 1'b0, 32'h0000_0100, 32'h0000_0080, 32'd5, 1'b0, 1'b0, 1'b0,
      1'b1, 32'd4, 1'b1, 32'h0000_0080, 1'b0, 7'h00, 4'd3},
    // R4 decrement to zero, faults ignored
    '{1'b1, 1'b0, 32'h0000_0100, 32'h0000_0080, 32'd1, 1'b1, 1'b0, 1'b1,
      1'b1, 32'd0, 1'b1, 32'h0000_0101, 1'b0, 7'h00, 4'd4},
    // R5 R6 decrement, protection abort
    '{1'b1, 1'b0, 32'h0000_0300, 32'h0000_0080, 32'd3, 1'b1, 1'b0, 1'b0,
      1'b0, 32'd0, 1'b0, 32'h0, 1'b1, 7'h40, 4'd6},
    // R5 R3 wrap from zero is taken; nonexistent abort
    '{1'b1, 1'b0, 32'h0000_0400, 32'h0000_0080, 32'd0, 1'b0, 1'b1, 1'b0,
      1'b0, 32'd0, 1'b0, 32'h0, 1'b1, 7'h40, 4'd5},
    // R7 decrement, parity abort
    '{1'b1, 1'b0, 32'h0000_0500, 32'h0000_0080, 32'd9, 1'b0, 1'b0, 1'b1,
      1'b0, 32'd0, 1'b0, 32'h0, 1'b1, 7'h4C, 4'd7},
    // R6 link, protection abort still writes link
    '{1'b0, 1'b0, 32'h0000_0700, 32'h0000_0080, 32'h0, 1'b1, 1'b0, 1'b0,
      1'b1, 32'h0000_0701, 1'b0, 32'h0, 1'b1, 7'h40, 4'd6},
    // R7 link extended, parity abort
    '{1'b0, 1'b1, 32'h0040_0010, 32'h0000_0080, 32'h0, 1'b0, 1'b0, 1'b1,
      1'b1, 32'h0000_0011, 1'b0, 32'h0, 1'b1, 7'h4C, 4'd7},
    // R8 link, nonexistent plus parity
    '{1'b0, 1'b0, 32'h0000_0020, 32'h0000_0080, 32'h0, 1'b0, 1'b1, 1'b1,
      1'b1, 32'h0000_0021, 1'b0, 32'h0, 1'b1, 7'h40, 4'd8},
    // R8 decrement, protection plus parity
    '{1'b1, 1'b0, 32'h0000_0600, 32'h0000_0080, 32'd7, 1'b1, 1'b0, 1'b1,
      1'b0, 32'd0, 1'b0, 32'h0, 1'b1, 7'h40, 4'd8}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idleCheck(input string tag);
    check(regWe == 1'b0, tag, "regWe idle", {31'b0, regWe}, 32'h0);
    check(iaWe == 1'b0, tag, "iaWe idle", {31'b0, iaWe}, 32'h0);
    check(trapReq == 1'b0, tag, "trapReq idle", {31'b0, trapReq}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    idleCheck("R9");
    rstN = 1'b1;
    @(negedge clk);
    idleCheck("R9");

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      op = VECS[i].op;
      extMode = VECS[i].ext;
      instAddr = VECS[i].ia;
      effAddr = VECS[i].eva;
      regIn = VECS[i].rin;
      faultProt = VECS[i].prot;
      faultNoMem = VECS[i].nomem;
      faultParity = VECS[i].par;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(regWe == VECS[i].eWe, tag, "regWe", {31'b0, regWe}, {31'b0, VECS[i].eWe});
      if (VECS[i].eWe)
        check(regData == VECS[i].eData, tag, "regData", regData, VECS[i].eData);
      check(iaWe == VECS[i].eIaWe, tag, "iaWe", {31'b0, iaWe}, {31'b0, VECS[i].eIaWe});
      if (VECS[i].eIaWe)
        check(iaOut == VECS[i].eIa, tag, "iaOut", iaOut, VECS[i].eIa);
      check(trapReq == VECS[i].eTrap, tag, "trapReq", {31'b0, trapReq}, {31'b0, VECS[i].eTrap});
      if (VECS[i].eTrap) begin
        check(trapVec == VECS[i].eVec, tag, "trapVec", {25'b0, trapVec}, {25'b0, VECS[i].eVec});
        // R5 saved address is the aborted instruction
        check(trapSaveAddr == VECS[i].ia, "R5", "trapSaveAddr", trapSaveAddr, VECS[i].ia);
      end
      @(negedge clk);
      // R9 single-cycle pulses
      idleCheck("R9");
    end

    // R9 back-to-back: a trap then a commit, each a pulse
    op = 1'b1; regIn = 32'd4; instAddr = 32'h0000_0900; effAddr = 32'h0000_0A00;
    faultProt = 1'b0; faultNoMem = 1'b0; faultParity = 1'b1; extMode = 1'b0;
    start = 1'b1;
    @(negedge clk);
    check(trapReq == 1'b1 && iaWe == 1'b0, "R9", "trap first",
          {30'b0, trapReq, iaWe}, 32'h2);
    faultParity = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(trapReq == 1'b0 && iaWe == 1'b1 && regData == 32'd3, "R3", "commit second",
          regData, 32'd3);
    @(negedge clk);
    idleCheck("R9");

    // R9 reset mid-stream clears strobes
    start = 1'b1; op = 1'b0;
    @(negedge clk);
    start = 1'b0;
    rstN = 1'b0;
    #1;
    idleCheck("R9");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    idleCheck("R9");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule